// File: doc/BRIEF.md
# Paper Tape Reader Word Assembler

This block is the reader controller of an 18-bit processor's input path. A tape frame source presents one 8-bit frame per cycle of `frm_valid`. The processor issues three commands. The alphanumeric read captures one whole frame. The binary read packs the low six bits of three marked frames into one 18-bit word, with the first frame in the top bits. The read-buffer command hands back the buffer contents and clears the status flag.

When a word is finished, one of two things happens. If the starting command asked for a completion pulse, the word goes straight to the processor's IO register, a restart pulse is given, and the status flag stays clear. Otherwise the status flag is set and a one-cycle interrupt request leaves the block, tagged with the configured 4-bit level. The alphanumeric command toggles the reader: issued while the reader is running, it only stops it.

Control is a three-state machine. IDLE means the reader is stopped. ALPHA means a one-frame read is in progress. BINARY means a three-group read is in progress.

The transitions are:
- IDLE to ALPHA on an alphanumeric command.
- Any state to BINARY on a binary command, which is also a restart when the reader is running.
- ALPHA or BINARY to IDLE on an alphanumeric command (stop).
- ALPHA to IDLE on any frame (completion).
- BINARY to IDLE on the third marked frame (completion).
- BINARY to BINARY on an unmarked frame, or on a marked frame that is not the last.

A start or stop command in the same cycle as a frame takes priority, and that frame is dropped.

Top module: `tape_word_asm`

## Requirements
- R1: After reset the reader is stopped (`reader_run`=0), the buffer is zero, `status_flag`=0, `wait_bit`=0, and no pulse output is active.
- R2: An alphanumeric read (`cmd_op`=2'b01 with the reader stopped) loads the full 8-bit frame, zero-extended, into the buffer and completes on that single frame.
- R3: A binary read (`cmd_op`=2'b10) fills the buffer from accepted frames in order. The first accepted frame's bits 5:0 go to buffer bits 17:12, the second to 11:6 and the third to 5:0. The read completes on the third accepted frame.
- R4: During a binary read, a frame whose bit 7 is 0 is skipped. The buffer does not change and the reader keeps running.
- R5: Starting either read clears the buffer to zero before any frame arrives.
- R6: An alphanumeric command issued while the reader is running stops the reader. The buffer, the status flag and the wait bit are left unchanged.
- R7: A binary command issued while a read is running restarts the read. The buffer is cleared, and the next accepted frame goes to bits 17:12.
- R8: If `cmd_cpls` was 1 on the starting command, completion gives a one-cycle `io_load` with the finished word on `io_word`, together with `restart` in the same cycle. `status_flag` is 0 afterwards and no interrupt is raised.
- R9: If `cmd_cpls` was 0, completion sets `status_flag` and gives a one-cycle `irq_req` with `irq_lvl` equal to `irq_level`.
- R10: A read-buffer command (`cmd_op`=2'b11) returns the buffer on `rd_data` with `rd_valid` one cycle later and clears `status_flag`. It does not stop or alter a running read. A completion in the same cycle wins over the clear.
- R11: A frame that arrives while the reader is stopped, or in the same cycle as a start or stop command, is dropped and does not change the buffer.
- R12: `wait_bit` takes the value of `cmd_wait` on every start command and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 alphanumeric read, 10 binary read, 11 read buffer, 00 none |
| cmd_cpls | input | 1 | Start command requests a completion pulse |
| cmd_wait | input | 1 | Wait bit carried by a start command |
| frm_valid | input | 1 | Frame strobe from the tape source |
| frm_data | input | 8 | Tape frame; bit 7 is the binary mark hole |
| irq_level | input | 4 | Interrupt level to tag requests with |
| rd_valid | output | 1 | Read-buffer result valid (one cycle) |
| rd_data | output | 18 | Buffer contents returned by read buffer |
| io_load | output | 1 | Finished word delivered to the IO register |
| io_word | output | 18 | Word delivered with `io_load` |
| restart | output | 1 | Processor restart pulse |
| status_flag | output | 1 | Data in buffer not yet taken |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_lvl | output | 4 | Level of the current interrupt request |
| reader_run | output | 1 | Reader is running (state not IDLE) |
| wait_bit | output | 1 | Wait bit of the last start command |

## Verification
Some properties are checked on every cycle by the assertions. In the stopped state the buffer cannot change. Unmarked binary frames leave both the state and the buffer alone. Every start leaves a zero buffer. A stop keeps the buffer. The shift position stays on a group boundary. A completion-pulse delivery never coincides with the flag or an interrupt. An interrupt always comes with the flag set. A read-buffer clears the flag. Other behaviour can only be shown by the bench's scenarios. These are the exact packed word values, restart in the middle of a word, the toggling stop, and the priority of a command over a simultaneous frame. They also include the buffer kept across a stop and observed through a later read-buffer.

// File: rtl/tape_pkg.sv
package tape_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALPHA  = 2'd1,
        ST_BINARY = 2'd2
    } rdr_state_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ALPHA  = 2'd1,
        OP_BINARY = 2'd2,
        OP_RDBUF  = 2'd3
    } rdr_op_t;
endpackage

// File: rtl/tape_cmd_decode.sv
module tape_cmd_decode
    import tape_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       running,
    output logic       start_alpha,
    output logic       start_bin,
    output logic       stop,
    output logic       rdbuf
);
    rdr_op_t op;

    always_comb begin
        op          = rdr_op_t'(cmd_op);
        start_alpha = 1'b0;
        start_bin   = 1'b0;
        stop        = 1'b0;
        rdbuf       = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_ALPHA:  begin
                    start_alpha = !running;
                    stop        = running;
                end
                OP_BINARY: start_bin = 1'b1;
                OP_RDBUF:  rdbuf     = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tape_shift_asm.sv
module tape_shift_asm #(
    parameter int FRAME_W = 8,
    parameter int GROUP_W = 6,
    parameter int GROUPS  = 3,
    localparam int WORD_W = GROUP_W * GROUPS,
    localparam int POS_W  = $clog2(WORD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load_alpha,
    input  logic               load_bin,
    input  logic [FRAME_W-1:0] frame,
    output logic [WORD_W-1:0]  word_q,
    output logic [WORD_W-1:0]  word_d,
    output logic               last_group
);
    logic [POS_W-1:0] pos_q, pos_d;

    always_comb begin
        pos_d  = pos_q;
        word_d = word_q;
        if (clear) begin
            pos_d  = POS_W'(WORD_W);
            word_d = '0;
        end else if (load_alpha) begin
            pos_d  = '0;
            word_d = WORD_W'(frame);
        end else if (load_bin) begin
            pos_d  = pos_q - POS_W'(GROUP_W);
            word_d = word_q | (WORD_W'(frame[GROUP_W-1:0]) << pos_d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            word_q <= '0;
        end else begin
            pos_q  <= pos_d;
            word_q <= word_d;
        end
    end

    assign last_group = (pos_q == POS_W'(GROUP_W));

    AST_POS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q <= POS_W'(WORD_W)) && ((pos_q % POS_W'(GROUP_W)) == '0)); // R3
endmodule

// File: rtl/tape_flag_irq.sv
module tape_flag_irq #(
    parameter int WORD_W = 18,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              cpls_pend,
    input  logic              rdbuf,
    input  logic [LVL_W-1:0]  level,
    input  logic [WORD_W-1:0] word_next,
    output logic              status_flag,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_lvl,
    output logic              io_load,
    output logic [WORD_W-1:0] io_word,
    output logic              restart
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_flag <= 1'b0;
            irq_req     <= 1'b0;
            irq_lvl     <= '0;
            io_load     <= 1'b0;
            io_word     <= '0;
            restart     <= 1'b0;
        end else begin
            irq_req <= 1'b0;
            io_load <= 1'b0;
            restart <= 1'b0;
            if (done && cpls_pend) begin
                io_load     <= 1'b1;
                io_word     <= word_next;
                restart     <= 1'b1;
                status_flag <= 1'b0;
            end else if (done) begin
                status_flag <= 1'b1;
                irq_req     <= 1'b1;
                irq_lvl     <= level;
            end else if (rdbuf) begin
                status_flag <= 1'b0;
            end
        end
    end

    AST_CPLS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        io_load |-> (!status_flag && !irq_req)); // R8
    AST_IRQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> status_flag); // R9
    AST_RDBUF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdbuf && !done) |=> !status_flag); // R10
endmodule

// File: rtl/tape_word_asm.sv
module tape_word_asm
    import tape_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int GROUP_W = 6,
    parameter int GROUPS  = 3,
    parameter int LVL_W   = 4,
    localparam int WORD_W = GROUP_W * GROUPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               cmd_cpls,
    input  logic               cmd_wait,
    input  logic               frm_valid,
    input  logic [FRAME_W-1:0] frm_data,
    input  logic [LVL_W-1:0]   irq_level,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               io_load,
    output logic [WORD_W-1:0]  io_word,
    output logic               restart,
    output logic               status_flag,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_lvl,
    output logic               reader_run,
    output logic               wait_bit
);
    rdr_state_t state_q, state_d;
    logic start_alpha, start_bin, stop, rdbuf, ctl_cmd;
    logic load_alpha, load_bin, done, last_group, cpls_pend;
    logic [WORD_W-1:0] word_q, word_d;

    tape_cmd_decode u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .running     (reader_run),
        .start_alpha (start_alpha),
        .start_bin   (start_bin),
        .stop        (stop),
        .rdbuf       (rdbuf)
    );

    assign ctl_cmd    = start_alpha || start_bin || stop;
    assign reader_run = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        load_alpha = 1'b0;
        load_bin   = 1'b0;
        done       = 1'b0;
        if (start_bin)        state_d = ST_BINARY;
        else if (start_alpha) state_d = ST_ALPHA;
        else if (stop)        state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ALPHA: if (frm_valid) begin
                    load_alpha = 1'b1;
                    done       = 1'b1;
                    state_d    = ST_IDLE;
                end
                ST_BINARY: if (frm_valid && frm_data[FRAME_W-1]) begin
                    load_bin = 1'b1;
                    if (last_group) begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpls_pend <= 1'b0;
            wait_bit  <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= rdbuf;
            if (rdbuf) rd_data <= word_q;
            if (start_alpha || start_bin) begin
                cpls_pend <= cmd_cpls;
                wait_bit  <= cmd_wait;
            end else if (done) begin
                cpls_pend <= 1'b0;
            end
        end
    end

    tape_shift_asm #(.FRAME_W(FRAME_W), .GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_alpha || start_bin),
        .load_alpha (load_alpha),
        .load_bin   (load_bin),
        .frame      (frm_data),
        .word_q     (word_q),
        .word_d     (word_d),
        .last_group (last_group)
    );

    tape_flag_irq #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .cpls_pend   (cpls_pend),
        .rdbuf       (rdbuf),
        .level       (irq_level),
        .word_next   (word_d),
        .status_flag (status_flag),
        .irq_req     (irq_req),
        .irq_lvl     (irq_lvl),
        .io_load     (io_load),
        .io_word     (io_word),
        .restart     (restart)
    );

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_alpha && !start_bin) |=> $stable(word_q)); // R11
    AST_NOMARK_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BINARY && frm_valid && !frm_data[FRAME_W-1] && !ctl_cmd)
        |=> (state_q == ST_BINARY && $stable(word_q))); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_alpha || start_bin) |=> (word_q == '0)); // R5
    AST_STOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == ST_IDLE && $stable(word_q) && $stable(status_flag))); // R6
endmodule

// File: tb/test_tape_word_asm.sv
module test_tape_word_asm;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_cpls = 1'b0;
    logic        cmd_wait = 1'b0;
    logic        frm_valid = 1'b0;
    logic [7:0]  frm_data = 8'd0;
    logic [3:0]  irq_level = 4'd5;
    logic        rd_valid, io_load, restart, status_flag, irq_req, reader_run, wait_bit;
    logic [17:0] rd_data, io_word;
    logic [3:0]  irq_lvl;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [17:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    tape_word_asm i_tape_word_asm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cpls(cmd_cpls), .cmd_wait(cmd_wait), .frm_valid(frm_valid),
        .frm_data(frm_data), .irq_level(irq_level), .rd_valid(rd_valid),
        .rd_data(rd_data), .io_load(io_load), .io_word(io_word), .restart(restart),
        .status_flag(status_flag), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .reader_run(reader_run), .wait_bit(wait_bit)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(int kind, logic [17:0] data, string tag);
        exp_t e;
        e.kind = kind;
        e.data = data;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic pop_cmp(int kind, logic [17:0] data);
        exp_t e;
        if (sb_q.size() == 0) begin
            chk("unexpected output kind", 32'(kind), 32'hFFFF);
        end else begin
            e = sb_q.pop_front();
            chk({e.tag, " kind"}, 32'(kind), 32'(e.kind));
            chk({e.tag, " data"}, 32'(data), 32'(e.data));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (io_load || restart) chk("R8 restart with io_load", 32'(restart), 32'(io_load));
            if (io_load) pop_cmp(0, io_word);
            if (irq_req) pop_cmp(1, 18'(irq_lvl));
            if (rd_valid) pop_cmp(2, rd_data);
        end
    end

    task automatic cmd(logic [1:0] op, logic cp, logic wt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cpls = cp; cmd_wait = wt;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_cpls = 1'b0; cmd_wait = 1'b0;
    endtask

    task automatic frame(logic [7:0] d);
        @(negedge clk);
        frm_valid = 1'b1; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0; frm_data = 8'd0;
    endtask

    task automatic rdbuf(logic [17:0] exp, string tag);
        expect_item(2, exp, tag);
        cmd(2'd3, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 run", 32'(reader_run), 0);
        chk("R1 flag", 32'(status_flag), 0);
        chk("R1 wait", 32'(wait_bit), 0);
        chk("R1 pulses", 32'({io_load, irq_req, restart, rd_valid}), 0);
        rdbuf(18'h0, "R1 buffer zero");

        // alphanumeric read, interrupt path
        cmd(2'd1, 1'b0, 1'b1);
        chk("R12 wait captured", 32'(wait_bit), 1);
        chk("R2 running", 32'(reader_run), 1);
        expect_item(1, 18'd5, "R9 irq level");
        frame(8'hA7);
        chk("R2 stops after one frame", 32'(reader_run), 0);
        chk("R9 flag set", 32'(status_flag), 1);
        rdbuf(18'h000A7, "R2 full frame");
        chk("R10 flag cleared", 32'(status_flag), 0);

        // binary read with completion pulse
        cmd(2'd2, 1'b1, 1'b0);
        chk("R12 wait follows command", 32'(wait_bit), 0);
        frame(8'h81);
        frame(8'h12);
        chk("R4 still running after unmarked", 32'(reader_run), 1);
        frame(8'hBF);
        expect_item(0, 18'h1FC3, "R3 R8 packed word");
        frame(8'hC3);
        chk("R8 flag stays clear", 32'(status_flag), 0);
        chk("R3 stopped after third group", 32'(reader_run), 0);

        // frames while stopped are dropped
        frame(8'h99);
        frame(8'hFF);
        rdbuf(18'h1FC3, "R11 idle frames dropped");

        // start with simultaneous frame: frame dropped, buffer cleared
        irq_level = 4'd9;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; frm_valid = 1'b1; frm_data = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; frm_valid = 1'b0; frm_data = 8'h0;
        chk("R11 command wins, running", 32'(reader_run), 1);
        rdbuf(18'h0, "R5 R11 cleared, frame dropped");
        chk("R10 read keeps reader running", 32'(reader_run), 1);
        expect_item(1, 18'd9, "R9 new level");
        frame(8'h3C);
        chk("R9 flag set again", 32'(status_flag), 1);

        // stop toggle keeps buffer and flag
        cmd(2'd2, 1'b0, 1'b1);
        frame(8'h85);
        cmd(2'd1, 1'b1, 1'b0);
        chk("R6 reader stopped", 32'(reader_run), 0);
        chk("R6 flag kept", 32'(status_flag), 1);
        chk("R6 wait kept", 32'(wait_bit), 1);
        frame(8'hFF);
        rdbuf(18'h05000, "R6 buffer kept");

        // restart in mid word
        cmd(2'd2, 1'b0, 1'b0);
        frame(8'h81);
        cmd(2'd2, 1'b0, 1'b0);
        chk("R7 running after restart", 32'(reader_run), 1);
        frame(8'h82);
        frame(8'h83);
        expect_item(1, 18'd9, "R7 irq after restart");
        frame(8'h84);
        rdbuf(18'h020C4, "R7 restarted word");

        // start clears buffer immediately
        cmd(2'd2, 1'b0, 1'b0);
        rdbuf(18'h0, "R5 start clears");
        cmd(2'd1, 1'b0, 1'b0);
        chk("R6 stop binary", 32'(reader_run), 0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 32'(sb_q.size()), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule